// File: doc/BRIEF.md
# Serial Host Register Interface

This block is a slave serial port through which a host microcontroller reads and writes a small on-chip register file. The host uses four wires: an active-low select, a data clock, serial data in and serial data out with an output enable. All four are sampled by a faster system clock, passed through two-flop synchronisers, and the data clock is edge-detected in that domain.

A frame begins with a direction bit: 1 for a write, 0 for a read. A 7-bit address follows, most significant bit first. A write then carries 8 data bits. On a read the block turns its output driver on once the last address bit is in, and shifts data out on falling clock edges. Writes to the seven command addresses 0x20 to 0x26 change no register. Each one fires a single-cycle strobe.

The block also keeps a 12-bit sticky event register. Reading it clears the bits that were read, and that read is also the only way to release the interrupt output. An enabled event that arrives during that read stays in the register for the next read, and the interrupt gives a short pulse when the read ends.

Top module: `hostser_regif`

## Requirements
- R1: While select is low, a frame of direction bit 1, a 7-bit address (MSB first) and 8 data bits (MSB first) sampled on rising data-clock edges writes the data into register file entry 0x00 to 0x07 named by the address.
- R2: A frame with direction bit 0 and an address in 0x00..0x07 returns that register's 8 bits, MSB first. A new bit is presented after each falling data-clock edge, so the host samples bit 7 at the 9th rising edge.
- R3: The output enable is low during every write frame and whenever select is high. It is high during a read from the completion of the 7th address bit until select returns high.
- R4: After reset every register reads 0 except entry 0x06, a coefficient register, which reads 0x14.
- R5: A read of address 0x60 returns the 12-bit event register, bit 11 first, and clears the bits it returned. An immediate second read returns 0.
- R6: An event input pulse sets its event bit whatever its enable says. The interrupt asserts only for enabled events. Entry 0x03 bits 7:0 enable events 7:0, and entry 0x04 bits 3:0 enable events 11:8.
- R7: Once asserted, the interrupt stays high through an event read and drops when that read's 12th data bit has been received.
- R8: An enabled event that arrives during an event read stays set for the next read. When the read ends, the interrupt stays high for a further PULSE_CYC system cycles (125 by default, 1 µs at 125 MHz) and then falls.
- R9: A write frame to address 0x20+k (k = 0..6) drives command strobe bit k high for exactly one system cycle. Its data bits are ignored and no register changes.
- R10: A frame that ends with select high before all of its data bits have arrived performs no write. For an event read, it clears no event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low frame select |
| dclk_i | input | 1 | Serial data clock |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| dout_oe_o | output | 1 | Output enable for dout_o (low = high impedance) |
| events_i | input | 12 | Event pulses, one bit per source |
| irq_o | output | 1 | Interrupt request, active high |
| cmd_stb_o | output | 7 | One-cycle command strobes for addresses 0x20..0x26 |
| regs_o | output | 64 | Register file contents, entry n at bits 8n+7:8n |

## Verification
The bench targets the timing of the first read bit. A design that loads the output shifter one edge late, or shifts on the falling edge right after the address, returns every byte rotated by one bit. It checks that the interrupt is held through an event read and released only at the 12th bit, and that an enabled event landing inside that read survives to the next read with a release pulse. A design that clears the whole register at copy time loses that event, and one that keeps the interrupt as a plain level never lets it fall. Truncated frames are sent to show that a register or an event bit committed on address alone is a fault. Command writes carrying all-ones data show whether a design leaks dummy data into the register file or stretches a strobe.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int NEVT   = 12;
  localparam int NCMD   = 7;
  localparam int CNT_W  = 5;
  localparam logic [ADDR_W-1:0] EVT_ADDR = 7'h60;
  localparam logic [ADDR_W-1:0] CMD_BASE = 7'h20;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NEVT-1:0]   evt_t;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/hsr_frame.sv
module hsr_frame
  import hsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_n_i,
  input  logic  dclk_i,
  input  logic  din_i,
  input  byte_t rd_data_i,
  input  evt_t  evt_i,
  output logic  wr_stb_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output addr_t rd_addr_o,
  output logic  evt_copy_o,
  output logic  evt_busy_o,
  output logic  evt_done_o,
  output logic  dout_o,
  output logic  dout_oe_o
);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] WR_END   = CNT_W'(ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] EV_END   = CNT_W'(ADDR_W + NEVT);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic             dclk_q, rise, fall;
  logic [CNT_W-1:0] cnt_q;
  logic             is_wr_q, evt_rd_q;
  addr_t            addr_q, a_full;
  logic [DATA_W-2:0] data_q;
  evt_t             sh_q;
  logic             rd_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dclk_q <= 1'b0;
    else         dclk_q <= dclk_i;
  end
  assign rise = dclk_i & ~dclk_q;
  assign fall = ~dclk_i & dclk_q;

  assign a_full = {addr_q[ADDR_W-2:0], din_i};
  assign rd_req = ~cs_n_i & rise & ~is_wr_q & (cnt_q == ADDR_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      is_wr_q  <= 1'b0;
      evt_rd_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      sh_q     <= '0;
    end else if (cs_n_i) begin
      cnt_q    <= '0;
      is_wr_q  <= 1'b0;
      evt_rd_q <= 1'b0;
    end else if (rise) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) is_wr_q <= din_i;
      else if (cnt_q <= ADDR_END) addr_q <= a_full;
      else if (cnt_q < WR_END) data_q <= {data_q[DATA_W-3:0], din_i};
      if (rd_req) begin
        evt_rd_q <= (a_full == EVT_ADDR);
        sh_q     <= (a_full == EVT_ADDR) ? evt_i : {rd_data_i, {(NEVT-DATA_W){1'b0}}};
      end
    end else if (fall && !is_wr_q && cnt_q > ADDR_END + 1'b1) begin
      sh_q <= {sh_q[NEVT-2:0], 1'b0};
    end
  end

  assign rd_addr_o  = a_full;
  assign evt_copy_o = rd_req & (a_full == EVT_ADDR);
  assign wr_stb_o   = ~cs_n_i & rise & is_wr_q & (cnt_q == WR_END);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = {data_q, din_i};
  assign evt_done_o = ~cs_n_i & rise & evt_rd_q & (cnt_q == EV_END);
  assign evt_busy_o = ~cs_n_i & evt_rd_q & (cnt_q <= EV_END);
  assign dout_oe_o  = ~cs_n_i & ~is_wr_q & (cnt_q > ADDR_END);
  assign dout_o     = sh_q[NEVT-1];

  AST_OE_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> $past(rise)); // R3
  AST_WR_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(!cs_n_i)); // R10
endmodule

// File: rtl/hsr_regs.sv
module hsr_regs
  import hsr_pkg::*;
#(
  parameter int    NREG     = 8,
  parameter int    COEF_IDX = 6,
  parameter byte_t COEF_RST = 8'h14,
  parameter int    EN_LO    = 3,
  parameter int    EN_HI    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_stb_i,
  input  addr_t                  wr_addr_i,
  input  byte_t                  wr_data_i,
  input  addr_t                  rd_addr_i,
  output byte_t                  rd_data_o,
  output evt_t                   irq_en_o,
  output logic [NCMD-1:0]        cmd_stb_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [NCMD-1:0]             cmd_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= (i == COEF_IDX) ? COEF_RST : '0;
    end else if (wr_stb_i && wr_addr_i < ADDR_W'(NREG)) begin
      regs_q[wr_addr_i[IW-1:0]] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i < ADDR_W'(NREG)) ? regs_q[rd_addr_i[IW-1:0]] : '0;
  assign irq_en_o  = {regs_q[EN_HI][NEVT-DATA_W-1:0], regs_q[EN_LO]};
  assign regs_o    = regs_q;

  for (genvar k = 0; k < NCMD; k++) begin : g_cmd
    assign cmd_hit[k] = wr_stb_i && (wr_addr_i == ADDR_W'(int'(CMD_BASE) + k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_stb_o <= '0;
    else         cmd_stb_o <= cmd_hit;
  end

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_stb_o)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_stb_o) |=> !(|cmd_stb_o)); // R9
endmodule

// File: rtl/hsr_events.sv
module hsr_events
  import hsr_pkg::*;
#(
  parameter int PULSE_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t events_i,
  input  evt_t en_i,
  input  logic copy_i,
  input  logic busy_i,
  input  logic done_i,
  output evt_t evt_o,
  output logic irq_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  evt_t          evt_q, shadow_q;
  logic          irq_q, pend_q, hit;
  logic [PW-1:0] pcnt_q;

  assign hit = |(events_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      shadow_q <= '0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
      pcnt_q   <= '0;
    end else begin
      if (copy_i) shadow_q <= evt_q;
      evt_q <= done_i ? ((evt_q & ~shadow_q) | events_i) : (evt_q | events_i);
      if (done_i || !(busy_i || copy_i)) pend_q <= 1'b0;
      else if (hit)                      pend_q <= 1'b1;
      if (done_i) begin
        irq_q  <= 1'b0;
        pcnt_q <= (pend_q || hit) ? PW'(PULSE_CYC) : '0;
      end else begin
        if (hit) irq_q <= 1'b1;
        if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
      end
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q | (pcnt_q != '0);

  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !pend_q && !hit && pcnt_q == '0) |=> !irq_o); // R7
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt_q == PW'(1) && !irq_q && !done_i && !hit) |=> !irq_o); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(hit)); // R6
endmodule

// File: rtl/hostser_regif.sv
module hostser_regif
  import hsr_pkg::*;
#(
  parameter int    NREG      = 8,
  parameter int    COEF_IDX  = 6,
  parameter byte_t COEF_RST  = 8'h14,
  parameter int    PULSE_CYC = 125
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   dclk_i,
  input  logic                   din_i,
  output logic                   dout_o,
  output logic                   dout_oe_o,
  input  logic [NEVT-1:0]        events_i,
  output logic                   irq_o,
  output logic [NCMD-1:0]        cmd_stb_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic  cs_s, dclk_s, din_s;
  logic  wr_stb, evt_copy, evt_busy, evt_done;
  addr_t wr_addr, rd_addr;
  byte_t wr_data, rd_data;
  evt_t  evt_val, irq_en;

  hsr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({cs_ni, dclk_i, din_i}),
    .q_o   ({cs_s, dclk_s, din_s})
  );

  hsr_frame u_frame (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cs_n_i (cs_s), .dclk_i (dclk_s), .din_i (din_s),
    .rd_data_i (rd_data), .evt_i (evt_val),
    .wr_stb_o (wr_stb), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
    .rd_addr_o (rd_addr), .evt_copy_o (evt_copy), .evt_busy_o (evt_busy),
    .evt_done_o (evt_done), .dout_o (dout_o), .dout_oe_o (dout_oe_o)
  );

  hsr_regs #(.NREG(NREG), .COEF_IDX(COEF_IDX), .COEF_RST(COEF_RST)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_stb_i (wr_stb), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data), .irq_en_o (irq_en),
    .cmd_stb_o (cmd_stb_o), .regs_o (regs_o)
  );

  hsr_events #(.PULSE_CYC(PULSE_CYC)) u_events (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .events_i (events_i), .en_i (irq_en),
    .copy_i (evt_copy), .busy_i (evt_busy), .done_i (evt_done),
    .evt_o (evt_val), .irq_o (irq_o)
  );
endmodule

// File: tb/sim_hostser_regif.sv
module sim_hostser_regif;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, dclk = 1'b0, din = 1'b0;
  logic        dout, dout_oe, irq;
  logic [11:0] events = '0;
  logic [6:0]  cmd_stb;
  logic [63:0] regs;

  int n_vec = 0, n_bad = 0, stb_cycles = 0, oe_in_write = 0;
  logic [6:0] stb_last = '0;
  bit in_wr = 0, done = 0;

  logic [11:0] exp_q[$], got_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  hostser_regif u0 (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .dclk_i (dclk), .din_i (din),
    .dout_o (dout), .dout_oe_o (dout_oe), .events_i (events), .irq_o (irq),
    .cmd_stb_o (cmd_stb), .regs_o (regs)
  );

  always @(negedge clk) begin
    if (cmd_stb != '0) begin stb_cycles++; stb_last = cmd_stb; end
    if (in_wr && dout_oe) oe_in_write++;
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      logic [11:0] e, g;
      string t;
      e = exp_q.pop_front(); g = got_q.pop_front(); t = tag_q.pop_front();
      n_vec++;
      if (e !== g) begin
        n_bad++;
        $display("FAIL %s read: got %h expected %h", t, g, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    din = b;
    repeat (8) @(negedge clk);
    dclk = 1'b1;
    repeat (8) @(negedge clk);
    dclk = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [6:0] a, input logic [7:0] d,
                      input int nd, output logic [11:0] got);
    got = '0;
    in_wr = wr;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    send_bit(wr);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    for (int i = 0; i < nd; i++) begin
      if (wr) send_bit(d[7-i % 8]);
      else begin
        din = 1'b0;
        repeat (8) @(negedge clk);
        if (!dout_oe) begin
          n_vec++; n_bad++;
          $display("FAIL R3: dout_oe got 0 expected 1 at data bit %0d", i);
        end
        got = {got[10:0], dout};
        dclk = 1'b1;
        repeat (8) @(negedge clk);
        dclk = 1'b0;
      end
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    in_wr = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [11:0] g;
    xfer(1'b1, a, d, 8, g);
  endtask

  task automatic rd_chk(input logic [6:0] a, input int nd, input logic [11:0] e, input string tag);
    logic [11:0] g;
    exp_q.push_back(e); tag_q.push_back(tag);
    xfer(1'b0, a, 8'h00, nd, g);
    got_q.push_back(g);
    @(negedge clk);
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk); events = 12'(1 << idx);
    @(negedge clk); events = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] g;
    int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state: R4, R3
    chk("R3 oe idle", {11'b0, dout_oe}, 12'h0);
    chk("R6 irq reset", {11'b0, irq}, 12'h0);
    rd_chk(7'h00, 8, 12'h000, "R4 reg00");
    rd_chk(7'h06, 8, 12'h014, "R4 coef reg06");
    rd_chk(7'h03, 8, 12'h000, "R4 reg03");
    chk("R3 oe after cs high", {11'b0, dout_oe}, 12'h0);

    // write then read back: R1, R2
    wr_reg(7'h00, 8'hA5);
    wr_reg(7'h01, 8'h3C);
    wr_reg(7'h07, 8'h81);
    rd_chk(7'h00, 8, 12'h0A5, "R1 R2 reg00");
    rd_chk(7'h01, 8, 12'h03C, "R1 R2 reg01");
    rd_chk(7'h07, 8, 12'h081, "R1 R2 reg07");
    chk("R3 oe during writes", 12'(oe_in_write), 12'h0);

    // command strobes: R9
    s0 = stb_cycles;
    wr_reg(7'h23, 8'hFF);
    chk("R9 strobe cycles 0x23", 12'(stb_cycles - s0), 12'h1);
    chk("R9 strobe bit 0x23", {5'b0, stb_last}, 12'h008);
    s0 = stb_cycles;
    wr_reg(7'h20, 8'hFF);
    chk("R9 strobe cycles 0x20", 12'(stb_cycles - s0), 12'h1);
    chk("R9 strobe bit 0x20", {5'b0, stb_last}, 12'h001);
    chk("R9 regs untouched", 12'(regs[63:0] == 64'h8114_0000_0000_3CA5), 12'h1);

    // event set without enable: R6, R5
    pulse_evt(2);
    repeat (4) @(negedge clk);
    chk("R6 irq masked", {11'b0, irq}, 12'h0);
    rd_chk(7'h60, 12, 12'h004, "R5 event read");
    rd_chk(7'h60, 12, 12'h000, "R5 event cleared");

    // enabled event, irq held through read: R6, R7
    wr_reg(7'h03, 8'h01);
    wr_reg(7'h04, 8'h08);
    pulse_evt(0);
    repeat (4) @(negedge clk);
    chk("R6 irq enabled event", {11'b0, irq}, 12'h1);
    fork
      rd_chk(7'h60, 12, 12'h001, "R7 event read");
      begin repeat (300) @(negedge clk); chk("R7 irq held mid-read", {11'b0, irq}, 12'h1); end
    join
    chk("R7 irq released", {11'b0, irq}, 12'h0);

    // enabled event during read: R8
    pulse_evt(11);
    repeat (4) @(negedge clk);
    chk("R6 irq event 11", {11'b0, irq}, 12'h1);
    fork
      rd_chk(7'h60, 12, 12'h800, "R8 event read");
      begin repeat (200) @(negedge clk); pulse_evt(0); end
    join
    chk("R8 irq pulse after read", {11'b0, irq}, 12'h1);
    repeat (130) @(negedge clk);
    chk("R8 irq pulse ends", {11'b0, irq}, 12'h0);
    rd_chk(7'h60, 12, 12'h001, "R8 kept event");

    // truncated frames: R10
    xfer(1'b1, 7'h01, 8'hFF, 4, g);
    rd_chk(7'h01, 8, 12'h03C, "R10 short write");
    wr_reg(7'h03, 8'h00);
    pulse_evt(5);
    xfer(1'b0, 7'h60, 8'h00, 6, g);
    rd_chk(7'h60, 12, 12'h020, "R10 short event read");

    repeat (20) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule